// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address used for each beat of a four-beat burst into a synchronous memory. A burst starts when either of two active-low start strobes is asserted. One strobe comes from the processor side and one from the controller side. The strobe captures the external address as the burst base and clears an internal beat counter. After the start, the low two address bits are generated internally. The beat counter steps only on clock edges where the active-low advance input is low. On all other edges the address is held.

An order-select input picks how the low bits follow the beat count. In wrapping increment (linear) order they are the base low bits plus the beat count. In interleaved order they are the base low bits XOR the beat count. The order select is registered, so a change on it takes effect one clock edge later than the change itself. The upper address bits come only from the captured base and never take a carry from the beat counter. The reset value of the order register is interleaved, which matches a selector that is normally pulled high.

The block uses an asynchronous active-low reset. The reset is released synchronously through a two-stage synchronizer, so the block leaves reset two clock edges after `rst_ni` rises.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is applied, and after it is released with no strobe or advance, `burst_addr_o` is all zeros.
- R2: An edge with `proc_start_n_i` low makes `burst_addr_o` equal to `addr_i` from that edge, and restarts the beat count at zero.
- R3: An edge with `ctrl_start_n_i` low does the same load as R2.
- R4: An edge with both strobes high and `adv_n_i` low moves the beat count on by one, so the low two output bits change.
- R5: An edge with both strobes high, `adv_n_i` high and an unchanged order select leaves `burst_addr_o` unchanged.
- R6: With `order_sel_i` = 0 (linear), the low two output bits equal (base low bits + beat count) mod 4.
- R7: With `order_sel_i` = 1 (interleaved), the low two output bits equal base low bits XOR beat count.
- R8: After four advances, the address returns to the base. Bits above bit 1 never change except on a load.
- R9: When a start strobe and advance are both asserted at the same edge, the load wins and the output equals `addr_i`.
- R10: `order_sel_i` is sampled at each clock edge, and the output uses the order sampled at the most recent edge. The reset value of the order is interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| proc_start_n_i | input | 1 | Active-low burst start from the processor side |
| ctrl_start_n_i | input | 1 | Active-low burst start from the controller side |
| adv_n_i | input | 1 | Active-low beat advance |
| order_sel_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr_i | input | ADDR_W | External address captured on a start |
| burst_addr_o | output | ADDR_W | Current burst address |

## Verification
The assertions take the inputs to be driven to known levels once the synchronized reset has released. The hold and advance checks also require the order select to match the registered order on that edge. Without that, a mode change could move the low bits while neither a strobe nor an advance is present. The bench drives every input at the falling clock edge. Mode changes happen only on edges that also load, step or hold under a known order, so each property's precondition is either met or cleanly absent. Random phases use full-width addresses, so carry and wrap effects reach the upper bits whenever they are wrongly allowed to.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/burst_order_reg.sv
module burst_order_reg
  import burst_addr_pkg::*;
#(
  parameter order_e RST_ORDER = ORD_INTERLEAVE
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sel_i,
  output order_e order_o
);

  order_e order_q;
  order_e order_d;

  always_comb begin
    order_d = order_e'(sel_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      order_q <= RST_ORDER;
    end else begin
      order_q <= order_d;
    end
  end

  assign order_o = order_q;

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);

  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_d;
  logic              beat_en;

  always_comb begin
    beat_en = load_i | step_i;
    if (load_i) begin
      beat_d = '0;
    end else begin
      beat_d = beat_q + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  assign beat_o = beat_q;

endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
  import burst_addr_pkg::*;
#(
  parameter int unsigned BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] base_lo_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  order_e            order_i,
  output logic [BEAT_W-1:0] lo_o
);

  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] ilv_lo;

  // modular sum: carry out of the top beat bit is dropped
  assign lin_lo = base_lo_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_lo[b] = base_lo_i[b] ^ beat_i[b];
  end

  always_comb begin
    lo_o = (order_i == ORD_INTERLEAVE) ? ilv_lo : lin_lo;
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              proc_start_n_i,
  input  logic              ctrl_start_n_i,
  input  logic              adv_n_i,
  input  logic              order_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] burst_addr_o
);

  localparam int unsigned BEAT_W = $clog2(BURST_LEN);
  localparam int unsigned HI_W   = ADDR_W - BEAT_W;

  logic              rst_sync_n;
  logic              load;
  logic              step;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_d;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] seq_lo;
  order_e            order_q;

  burst_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  always_comb begin
    load   = ~proc_start_n_i | ~ctrl_start_n_i;
    step   = ~load & ~adv_n_i;
    base_d = addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      base_q <= '0;
    end else if (load) begin
      base_q <= base_d;
    end
  end

  burst_order_reg #(.RST_ORDER(ORD_INTERLEAVE)) u_order (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .sel_i   (order_sel_i),
    .order_o (order_q)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .load_i (load),
    .step_i (step),
    .beat_o (beat)
  );

  burst_seq_map #(.BEAT_W(BEAT_W)) u_map (
    .base_lo_i (base_q[BEAT_W-1:0]),
    .beat_i    (beat),
    .order_i   (order_q),
    .lo_o      (seq_lo)
  );

  assign burst_addr_o = {base_q[ADDR_W-1 -: HI_W], seq_lo};

endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned BEAT_W = 2
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              proc_start_n_i,
  input logic              ctrl_start_n_i,
  input logic              adv_n_i,
  input logic              order_sel_i,
  input logic              order_q,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] burst_addr_o
);

  logic quiet;
  assign quiet = proc_start_n_i & ctrl_start_n_i;

  p_reset_zero_r1: assert property (@(posedge clk_i)
    !rst_n |=> (!rst_n -> burst_addr_o == '0));

  p_proc_load_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !proc_start_n_i |=> burst_addr_o == $past(addr_i));

  p_ctrl_load_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ctrl_start_n_i |=> burst_addr_o == $past(addr_i));

  p_step_moves_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (quiet && !adv_n_i && order_sel_i == order_q)
      |=> burst_addr_o[BEAT_W-1:0] != $past(burst_addr_o[BEAT_W-1:0]));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (quiet && adv_n_i && order_sel_i == order_q) |=> $stable(burst_addr_o));

  p_upper_fixed_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    quiet |=> $stable(burst_addr_o[ADDR_W-1:BEAT_W]));

  p_start_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!adv_n_i && !(proc_start_n_i && ctrl_start_n_i))
      |=> burst_addr_o == $past(addr_i));

  p_order_latch_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> order_q == $past(order_sel_i));

endmodule

bind burst_addr_gen burst_addr_chk #(
  .ADDR_W (ADDR_W),
  .BEAT_W (BEAT_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_n          (rst_sync_n),
  .proc_start_n_i (proc_start_n_i),
  .ctrl_start_n_i (ctrl_start_n_i),
  .adv_n_i        (adv_n_i),
  .order_sel_i    (order_sel_i),
  .order_q        (order_q),
  .addr_i         (addr_i),
  .burst_addr_o   (burst_addr_o)
);

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;

  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          proc_n;
  logic          ctrl_n;
  logic          adv_n;
  logic          sel;
  logic [AW-1:0] addr;
  logic [AW-1:0] dut_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = 2'd0;
  logic          m_mode = 1'b1;

  always #5 clk = ~clk;

  burst_addr_gen u_burst_addr_gen (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .proc_start_n_i (proc_n),
    .ctrl_start_n_i (ctrl_n),
    .adv_n_i        (adv_n),
    .order_sel_i    (sel),
    .addr_i         (addr),
    .burst_addr_o   (dut_addr)
  );

  function automatic logic [AW-1:0] model_out();
    logic [1:0] lo;
    lo = m_mode ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
    return {m_base[AW-1:2], lo};
  endfunction

  // driver: apply inputs at the falling edge, predict the value after the next rising edge
  task automatic drive(input logic p, input logic c, input logic a, input logic s,
                       input logic [AW-1:0] ad, input string tag);
    @(negedge clk);
    proc_n = p; ctrl_n = c; adv_n = a; sel = s; addr = ad;
    if (!p || !c) begin
      m_base = ad; m_beat = 2'd0;
    end else if (!a) begin
      m_beat = m_beat + 2'd1;
    end
    m_mode = s;
    exp_q.push_back(model_out());
    tag_q.push_back(tag);
  endtask

  // monitor: sample 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [AW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (dut_addr !== e) begin
        errors++;
        $display("FAIL %s: actual=%05h expected=%05h", t, dut_addr, e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; proc_n = 1'b1; ctrl_n = 1'b1; adv_n = 1'b1; sel = 1'b1; addr = '0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (dut_addr !== '0) begin
      errors++;
      $display("FAIL R1 in reset: actual=%05h expected=00000", dut_addr);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(1, 1, 1, 1, 19'h7FFFF, "R1 idle");
    drive(1, 1, 0, 1, 19'h00000, "R1 adv after reset");

    drive(0, 1, 1, 1, 19'h12345, "R2 proc load");
    drive(1, 1, 0, 1, 19'h00000, "R7 ilv beat1");
    drive(1, 1, 0, 1, 19'h00000, "R7 ilv beat2");
    drive(1, 1, 0, 1, 19'h00000, "R7 ilv beat3");
    drive(1, 1, 0, 1, 19'h00000, "R8 ilv wrap");
    drive(1, 1, 1, 1, 19'h55555, "R5 hold");
    drive(1, 1, 1, 1, 19'h2AAAA, "R5 hold again");

    drive(1, 0, 1, 0, 19'h7FFF6, "R3 ctrl load");
    drive(1, 1, 0, 0, 19'h00000, "R6 lin beat1");
    drive(1, 1, 0, 0, 19'h00000, "R6 lin beat2 wrap low");
    drive(1, 1, 0, 0, 19'h00000, "R6 lin beat3");
    drive(1, 1, 0, 0, 19'h00000, "R8 lin wrap no carry");

    drive(1, 1, 0, 0, 19'h00000, "R4 step");
    drive(0, 1, 0, 0, 19'h0ABC1, "R9 proc beats adv");
    drive(1, 1, 0, 0, 19'h00000, "R4 step lin");
    drive(1, 0, 0, 1, 19'h31337, "R9 ctrl beats adv");

    drive(0, 1, 1, 0, 19'h00001, "R10 load lin");
    drive(1, 1, 0, 0, 19'h00000, "R10 lin step");
    drive(1, 1, 1, 1, 19'h00000, "R10 switch to ilv");
    drive(1, 1, 0, 1, 19'h00000, "R10 ilv step");
    drive(1, 1, 1, 0, 19'h00000, "R10 switch to lin");

    for (int i = 0; i < 60; i++) begin
      logic [2:0] r;
      r = 3'($urandom_range(0, 7));
      drive(!(r == 3'd0), !(r == 3'd1), r[2], 1'($urandom_range(0, 1)),
            AW'($urandom), "R4 R6 R7 random");
    end

    drive(1, 1, 1, sel, 19'h00000, "R5 final hold");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule